// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the serial test port of a device that carries a boundary-scan chain. It follows the standard sixteen-state test-port state machine, clocked by the test clock and steered by the mode-select input. It owns an 8-bit instruction register, a one-stage bypass register and a 32-bit identification register. The boundary cells live outside; the block tells them when to capture, shift and update, and it reads their serial output back onto the test data output.

Two things set it apart from a bare controller. First, the instruction register captures the code of the sample/preload instruction, so a pass through the IR column that skips shifting makes sample/preload current. Second, three extra instructions restrict scanning to the input half or the output half of the boundary chain, one of them driving outputs from the update latches. Clamp and high-impedance instructions route the bypass stage between TDI and TDO and put the pins in a fixed mode.

Top module: `scan_tap`

## Requirements
- R1: A synchronous reset (`rst` high at a rising `tck`), or `trst_n` low when the TRST option is on, puts the port in Test-Logic-Reset. The identification instruction becomes current: `bsr_sel`, `mode_drive`, `mode_clamp`, `mode_hiz` are 0, `chain_half` is 0, and `tdo_en` is 0.
- R2: Five rising `tck` edges with `tms` high reach Test-Logic-Reset from any state. Being in that state makes the identification instruction current.
- R3: In Capture-IR the instruction shift register loads 8'b1000_0001. Shifting moves it LSB first onto `tdo`, with `tdi` entering at the MSB.
- R4: The path Capture-IR, Exit1-IR, Update-IR with no shift makes sample/preload current: `bsr_sel`=1, `mode_drive`=0, `chain_half`=0.
- R5: Decoding, with `chain_half` 0 = whole chain, 1 = input half, 2 = output half. 8'h00 test-drive: bsr_sel=1, drive=1. 8'h81 sample/preload: bsr_sel=1. 8'h82 clamp: drive=1, clamp=1, bypass stage. 8'h03 high-Z: hiz=1, bypass stage. 8'h41 sample-in: bsr_sel=1, half=1. 8'h42 sample-out: bsr_sel=1, half=2. 8'h22 test-drive-out: bsr_sel=1, drive=1, half=2. 8'hAA: identification register. 8'hFF: bypass stage. All flags not listed are 0.
- R6: Any other 8-bit code decodes exactly as 8'hFF.
- R7: The bypass stage captures 0 in Capture-DR. During Shift-DR it delays `tdi` by one `tck`, so the first bit out is 0.
- R8: When the identification register is selected, Capture-DR loads the 32-bit `ID_VALUE` with bit 0 forced to 1. Shift-DR moves it out LSB first.
- R9: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is 1 only while the state is Shift-IR or Shift-DR.
- R10: `bsr_capture`, `bsr_shift` and `bsr_update` pulse only in Capture-DR, Shift-DR and Update-DR, and only while `bsr_sel` is 1. In Shift-DR, `tdo` then follows `bsr_so`.
- R11: Clamp and high-Z never select the boundary chain (`bsr_sel`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| trst_n | input | 1 | Optional test reset, active low, sampled on tck |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_en | output | 1 | High while tdo carries shift data |
| bsr_si | output | 1 | Serial input toward the boundary chain |
| bsr_so | input | 1 | Serial output of the boundary chain |
| bsr_sel | output | 1 | Boundary chain is the active data register |
| bsr_capture | output | 1 | Boundary cells capture this cycle |
| bsr_shift | output | 1 | Boundary cells shift this cycle |
| bsr_update | output | 1 | Boundary update latches load this cycle |
| mode_drive | output | 1 | Pins driven from boundary update latches |
| mode_clamp | output | 1 | Clamp instruction is current |
| mode_hiz | output | 1 | All pins forced to high impedance |
| chain_half | output | 2 | 0 whole chain, 1 input half, 2 output half |

## Verification
The hardest situations to reach from the pins are Test-Logic-Reset entered from deep inside a shift, and the Update-IR reached straight from Capture-IR with no shift. Both need exact tms sequences, not register writes. The bench drives five high tms bits from inside Shift-DR, and walks the capture-exit-update path after another instruction was made current, so that the change of flags is visible. Random opcodes, about a third of them outside the defined set, are loaded and then scanned through whichever register they select.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;
  localparam int IR_W = 8;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR} dr_sel_t;

  localparam logic [1:0] HALF_ALL = 2'd0;
  localparam logic [1:0] HALF_IN  = 2'd1;
  localparam logic [1:0] HALF_OUT = 2'd2;

  localparam logic [IR_W-1:0] OP_TDRIVE     = 8'h00;
  localparam logic [IR_W-1:0] OP_SAMPLE     = 8'h81;
  localparam logic [IR_W-1:0] OP_CLAMP      = 8'h82;
  localparam logic [IR_W-1:0] OP_HIZ        = 8'h03;
  localparam logic [IR_W-1:0] OP_SAMPLE_IN  = 8'h41;
  localparam logic [IR_W-1:0] OP_SAMPLE_OUT = 8'h42;
  localparam logic [IR_W-1:0] OP_TDRIVE_OUT = 8'h22;
  localparam logic [IR_W-1:0] OP_IDENT      = 8'hAA;
  localparam logic [IR_W-1:0] OP_BYPASS     = 8'hFF;
  localparam logic [IR_W-1:0] IR_CAPTURE    = OP_SAMPLE;

  typedef struct packed {
    dr_sel_t    dr;
    logic       drive;
    logic       clamp;
    logic       hiz;
    logic [1:0] half;
  } tap_mode_t;

  function automatic tap_mode_t decode_op(input logic [IR_W-1:0] op);
    tap_mode_t m;
    m = '{dr: DR_BYP, drive: 1'b0, clamp: 1'b0, hiz: 1'b0, half: HALF_ALL};
    case (op)
      OP_TDRIVE:     begin m.dr = DR_BSR; m.drive = 1'b1; end
      OP_SAMPLE:     m.dr = DR_BSR;
      OP_CLAMP:      begin m.drive = 1'b1; m.clamp = 1'b1; end
      OP_HIZ:        m.hiz = 1'b1;
      OP_SAMPLE_IN:  begin m.dr = DR_BSR; m.half = HALF_IN; end
      OP_SAMPLE_OUT: begin m.dr = DR_BSR; m.half = HALF_OUT; end
      OP_TDRIVE_OUT: begin m.dr = DR_BSR; m.drive = 1'b1; m.half = HALF_OUT; end
      OP_IDENT:      m.dr = DR_ID;
      default:       m.dr = DR_BYP;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_TLR;
    else     state <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tdi,
  input  tap_state_t state,
  output logic       ir_so,
  output tap_mode_t  mode
);
  logic [IR_W-1:0] sh;

  always_ff @(posedge tck) begin
    if (rst) begin
      sh   <= IR_CAPTURE;
      mode <= decode_op(OP_IDENT);
    end else begin
      case (state)
        ST_TLR:    mode <= decode_op(OP_IDENT);
        ST_CAP_IR: sh   <= IR_CAPTURE;
        ST_SH_IR:  sh   <= {tdi, sh[IR_W-1:1]};
        ST_UPD_IR: mode <= decode_op(sh);
        default:   ;
      endcase
    end
  end

  assign ir_so = sh[0];
endmodule

// File: rtl/tap_dregs.sv
module tap_dregs
  import scan_tap_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0B2E_4C35
) (
  input  logic       tck,
  input  logic       rst,
  input  logic       tdi,
  input  tap_state_t state,
  input  dr_sel_t    dr,
  output logic       byp_so,
  output logic       id_so
);
  localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};

  logic            byp;
  logic [ID_W-1:0] idr;

  always_ff @(posedge tck) begin
    if (rst) begin
      byp <= 1'b0;
      idr <= ID_CAP;
    end else begin
      if (state == ST_CAP_DR) begin
        byp <= 1'b0;
        if (dr == DR_ID) idr <= ID_CAP;
      end else if (state == ST_SH_DR) begin
        byp <= tdi;
        if (dr == DR_ID) idr <= {tdi, idr[ID_W-1:1]};
      end
    end
  end

  assign byp_so = byp;
  assign id_so  = idr[0];
endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0B2E_4C35,
  parameter bit              USE_TRST = 1'b1
) (
  input  logic       tck,
  input  logic       rst,
  input  logic       trst_n,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdo_en,
  output logic       bsr_si,
  input  logic       bsr_so,
  output logic       bsr_sel,
  output logic       bsr_capture,
  output logic       bsr_shift,
  output logic       bsr_update,
  output logic       mode_drive,
  output logic       mode_clamp,
  output logic       mode_hiz,
  output logic [1:0] chain_half
);
  logic       tap_rst;
  tap_state_t state;
  tap_mode_t  mode;
  logic       ir_so, byp_so, id_so;

  generate
    if (USE_TRST) begin : g_trst
      assign tap_rst = rst | ~trst_n;
    end else begin : g_no_trst
      assign tap_rst = rst;
    end
  endgenerate

  tap_fsm u_fsm (.tck(tck), .rst(tap_rst), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .rst(tap_rst), .tdi(tdi), .state(state),
               .ir_so(ir_so), .mode(mode));

  tap_dregs #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dregs (
    .tck(tck), .rst(tap_rst), .tdi(tdi), .state(state), .dr(mode.dr),
    .byp_so(byp_so), .id_so(id_so));

  always_ff @(negedge tck) begin
    if (tap_rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
      if (state == ST_SH_IR) tdo <= ir_so;
      else if (state == ST_SH_DR) begin
        case (mode.dr)
          DR_ID:   tdo <= id_so;
          DR_BSR:  tdo <= bsr_so;
          default: tdo <= byp_so;
        endcase
      end
    end
  end

  assign bsr_si      = tdi;
  assign bsr_sel     = (mode.dr == DR_BSR);
  assign bsr_capture = bsr_sel && (state == ST_CAP_DR);
  assign bsr_shift   = bsr_sel && (state == ST_SH_DR);
  assign bsr_update  = bsr_sel && (state == ST_UPD_DR);
  assign mode_drive  = mode.drive;
  assign mode_clamp  = mode.clamp;
  assign mode_hiz    = mode.hiz;
  assign chain_half  = mode.half;
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic       tck,
  input logic       rst,
  input logic       tms,
  input tap_state_t state,
  input logic       tdo_en,
  input logic       bsr_sel,
  input logic       bsr_capture,
  input logic       bsr_shift,
  input logic       bsr_update,
  input logic       mode_drive,
  input logic       mode_clamp,
  input logic       mode_hiz,
  input logic [1:0] chain_half
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck) begin
    if (rst)              ones_cnt <= '0;
    else if (!tms)        ones_cnt <= '0;
    else if (ones_cnt < 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (rst)
    (ones_cnt == 3'd5) |-> (state == ST_TLR));

  a_r2_tlr_loads_ident: assert property (@(posedge tck) disable iff (rst)
    (state == ST_TLR) |=> (!bsr_sel && !mode_drive && !mode_clamp && !mode_hiz && chain_half == 2'd0));

  a_r9_tdo_en_shift_only: assert property (@(posedge tck) disable iff (rst)
    tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

  a_r10_strobes_need_sel: assert property (@(posedge tck) disable iff (rst)
    (bsr_capture || bsr_shift || bsr_update) |-> bsr_sel);

  a_r10_one_strobe: assert property (@(posedge tck) disable iff (rst)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  a_r11_hiz_not_chain: assert property (@(posedge tck) disable iff (rst)
    (mode_hiz || mode_clamp) |-> !bsr_sel);

  a_r4_capture_update_sample: assert property (@(posedge tck) disable iff (rst)
    (state == ST_UPD_IR && $past(state) == ST_EX1_IR && $past(state, 2) == ST_CAP_IR)
      |=> (bsr_sel && !mode_drive && chain_half == 2'd0));
endmodule

bind scan_tap scan_tap_chk u_chk (
  .tck(tck), .rst(tap_rst), .tms(tms), .state(state), .tdo_en(tdo_en),
  .bsr_sel(bsr_sel), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
  .bsr_update(bsr_update), .mode_drive(mode_drive), .mode_clamp(mode_clamp),
  .mode_hiz(mode_hiz), .chain_half(chain_half));

// File: tb/scan_tap_tb.sv
`timescale 1ns/100ps
module scan_tap_tb;
  localparam logic [31:0] IDV = 32'h0B2E_4C35;

  logic tck = 1'b0, rst = 1'b1, trst_n = 1'b1, tms = 1'b1, tdi = 1'b0, bsr_so = 1'b0;
  logic tdo, tdo_en, bsr_si, bsr_sel, bsr_capture, bsr_shift, bsr_update;
  logic mode_drive, mode_clamp, mode_hiz;
  logic [1:0] chain_half;

  int checks = 0, errors = 0;
  logic s_tdo, s_en, s_cap, s_sh, s_upd;
  logic [31:0] dout;
  logic [7:0]  irout;
  int en_bad;

  always #2 tck = ~tck;

  scan_tap u_dut (.tck(tck), .rst(rst), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en), .bsr_si(bsr_si), .bsr_so(bsr_so), .bsr_sel(bsr_sel),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .mode_drive(mode_drive), .mode_clamp(mode_clamp), .mode_hiz(mode_hiz),
    .chain_half(chain_half));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // flags {bsr_sel, drive, clamp, hiz, half[1:0]} expected per R5/R6
  function automatic logic [5:0] exp_flags(input logic [7:0] op);
    case (op)
      8'h00: return 6'b110000;
      8'h81: return 6'b100000;
      8'h82: return 6'b011000;
      8'h03: return 6'b000100;
      8'h41: return 6'b100001;
      8'h42: return 6'b100010;
      8'h22: return 6'b110010;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic [5:0] flags();
    return {bsr_sel, mode_drive, mode_clamp, mode_hiz, chain_half};
  endfunction

  task automatic step(input logic t, input logic d);
    @(negedge tck); #0.5;
    s_tdo = tdo; s_en = tdo_en; s_cap = bsr_capture; s_sh = bsr_shift; s_upd = bsr_update;
    tms = t; tdi = d;
    @(posedge tck);
  endtask

  task automatic load_ir(input logic [7:0] op);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 8; i++) begin
      step(i == 7, op[i]);
      irout[i] = s_tdo;
    end
    step(1, 0); step(0, 0); #1;
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din);
    en_bad = 0;
    step(1, 0); if (s_en) en_bad++;
    step(0, 0); if (s_en) en_bad++;
    step(0, 0); if (s_en) en_bad++;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = s_tdo;
      if (!s_en) en_bad++;
      if (i == 0) s_cap = s_cap;
    end
    step(1, 0); if (s_en) en_bad++;
    step(0, 0); if (s_en) en_bad++;
    #1;
  endtask

  task automatic expect_id(input string req);
    scan_dr(32, $urandom());
    check(req, dout, IDV | 32'h1);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] op;
    logic [31:0] din;
    logic cap_seen;
    void'($urandom(32'd2024));
    repeat (3) @(posedge tck);
    #0.5 rst = 0;
    #1;
    // R1 reset state
    check("R1 flags", {26'd0, flags()}, 32'd0);
    check("R1 tdo_en", {31'd0, tdo_en}, 32'd0);
    step(0, 0);
    expect_id("R1 ident after reset");
    check("R8 id lsb", {31'd0, dout[0]}, 32'd1);
    check("R9 tdo_en only in shift", en_bad, 0);

    // R3 capture value shifted out of IR
    load_ir(8'hFF);
    check("R3 ir capture", {24'd0, irout}, 32'h81);
    // R7 bypass
    din = $urandom();
    scan_dr(16, din);
    check("R7 bypass first bit", {31'd0, dout[0]}, 32'd0);
    check("R7 bypass delay", {16'd0, dout[15:1]}, {17'd0, din[14:0]});

    // R4 capture-exit-update without shift
    load_ir(8'hAA);
    step(1, 0); step(1, 0); step(0, 0); step(1, 0); step(1, 0); step(0, 0); #1;
    check("R4 sample via no-shift", {26'd0, flags()}, {26'd0, exp_flags(8'h81)});

    // R10 boundary strobes and tdo from chain
    bsr_so = 1'b1;
    step(1, 0); cap_seen = 0;
    step(0, 0); step(0, 0); cap_seen = s_cap;
    for (int i = 0; i < 12; i++) begin
      step(i == 11, 0); dout[i] = s_tdo;
      if (!s_sh) cap_seen = 0;
    end
    step(1, 0); step(0, 0); #1;
    check("R10 capture+shift strobes", {31'd0, cap_seen}, 32'd1);
    check("R10 update strobe", {31'd0, s_upd}, 32'd1);
    check("R10 tdo follows chain", {20'd0, dout[11:0]}, 32'hFFF);

    // R11 clamp: bypass path even with chain output high
    load_ir(8'h82);
    scan_dr(8, 32'h0);
    check("R11 clamp uses bypass", {24'd0, dout[7:0]}, 32'd0);
    check("R5 clamp flags", {26'd0, flags()}, {26'd0, exp_flags(8'h82)});

    // R2 five ones from inside Shift-DR
    load_ir(8'hFF);
    step(1, 0); step(0, 0); step(0, 0); step(0, 0);
    repeat (5) step(1, 0);
    step(0, 0); #1;
    check("R2 five ones reset flags", {26'd0, flags()}, 32'd0);
    expect_id("R2 ident after five ones");

    // R1 trst_n
    load_ir(8'h03);
    @(negedge tck); trst_n = 0; @(negedge tck); trst_n = 1; #1;
    check("R1 trst flags", {26'd0, flags()}, 32'd0);
    step(0, 0);
    expect_id("R1 ident after trst");

    // R5 R6 random opcodes
    for (int k = 0; k < 60; k++) begin
      logic [7:0] known [9] = '{8'h00, 8'h81, 8'h82, 8'h03, 8'h41, 8'h42, 8'h22, 8'hAA, 8'hFF};
      if ($urandom() % 3 == 0) op = 8'($urandom());
      else op = known[$urandom() % 9];
      bsr_so = $urandom() % 2;
      load_ir(op);
      check((exp_flags(op) == 0 && op != 8'hAA) ? "R6 decode" : "R5 decode",
            {26'd0, flags()}, {26'd0, exp_flags(op)});
      din = $urandom();
      if (op == 8'hAA) expect_id("R8 ident scan");
      else if (exp_flags(op)[5]) begin
        scan_dr(8, din);
        check("R10 chain data", {24'd0, dout[7:0]}, {24'd0, {8{bsr_so}}});
      end else begin
        scan_dr(12, din);
        check("R6 R7 bypass scan", {20'd0, dout[11:0]}, {20'd0, din[10:0], 1'b0});
      end
      check("R9 tdo_en window", en_bad, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule